// File: doc/BRIEF.md
# Fractional-Rate Frame Sync Generator

This block turns a master clock into a divided serial bit clock and a frame strobe that marks the start of every input sample period. The sample period is the master clock divided by a programmable interpolation factor. That factor need not be a whole number of serial clock periods, so the block lets single frames run one serial clock longer or shorter. The long-run frame rate therefore stays exactly at the sample rate, and the timing error does not build up.

A phase counter runs at the master clock rate and wraps once per sample period. Each wrap arms a request. The strobe is raised on the next rising edge of the serial clock and stays high for one full serial clock period. After reset a fixed latency passes before the phase counter starts. A sleep input clears the phase, drops any pending request and holds the strobe low.

Top module: `fsg_frame_sync`

## Requirements
- R1: The serial clock output has a period of 2×(sclk_div+1) master clocks, with a high time of sclk_div+1 master clocks. sclk_div is a 5-bit unsigned value from 0 to 31.
- R2: Each frame strobe stays high for exactly one serial clock period, 2×(sclk_div+1) master clocks.
- R3: The frame strobe only rises on the same master clock edge at which the serial clock rises.
- R4: Every distance between successive strobe rises is S×floor(I/S) or S×ceil(I/S) master clocks, where S is the serial clock period and I is interp. When I is a multiple of S, all frame periods equal I.
- R5: The time from the first strobe to the n-th later strobe differs from n×I by less than S master clocks, for every n.
- R6: From the master clock edge after sleep is sampled high, the strobe is low and stays low while sleep stays high. After sleep is released, the next strobe rises between I-1 and I+S+1 master clocks later.
- R7: After reset is released, the first strobe rises no earlier than RST_LAT+I master clocks and no later than RST_LAT+I+S master clocks.
- R8: While reset is asserted, both the serial clock and the frame strobe are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sleep | input | 1 | Holds the strobe low and clears the sample phase |
| sclk_div | input | 5 | Serial clock divider setting |
| interp | input | INTERP_W | Master clocks per input sample (I) |
| sclk_out | output | 1 | Divided serial clock, 50% duty |
| sclk_en | output | 1 | One-master-clock pulse in the cycle before sclk_out rises |
| fsync | output | 1 | Frame strobe, one serial clock period wide |

## Verification
A phase counter that wraps at the wrong value shows up within one sample period. It moves the frame spacing off the two allowed multiples of S, and the cumulative drift grows past one serial clock within a few frames. A stuck or lost pending request shows up as a missing frame or as a strobe that does not line up with a serial clock rise. A wrong divider terminal count changes the serial clock period in its first cycle. A latency counter loaded with the wrong value moves the first strobe out of its window straight after reset.

// File: rtl/fsg_pkg.sv
package fsg_pkg;
  localparam int DIV_W = 5;
  typedef logic [DIV_W-1:0] sclk_div_t;

  // last phase index of a sample period; a zero factor behaves as one
  function automatic logic [31:0] last_phase(input logic [31:0] factor);
    return (factor == 32'd0) ? 32'd0 : factor - 32'd1;
  endfunction

  // master clocks in one serial clock period
  function automatic logic [31:0] sclk_cycles(input logic [31:0] div);
    return 32'd2 * (div + 32'd1);
  endfunction
endpackage

// File: rtl/fsg_sclk_div.sv
module fsg_sclk_div #(
  parameter int DIV_W = fsg_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             sclk,
  output logic             rise_evt,
  output logic             half_done
);
  logic [DIV_W-1:0] cnt;
  logic             sclk_q;

  assign half_done = (cnt >= div);
  assign rise_evt  = half_done && !sclk_q;
  assign sclk      = sclk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      sclk_q <= 1'b0;
    end else if (half_done) begin
      cnt    <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt    <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/fsg_phase_acc.sv
module fsg_phase_acc #(
  parameter int INTERP_W = 16,
  parameter int RST_LAT  = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sleep,
  input  logic [INTERP_W-1:0] interp,
  output logic                lat_done,
  output logic                wrap_evt
);
  localparam int LAT_W = (RST_LAT < 1) ? 1 : $clog2(RST_LAT + 1);

  logic [LAT_W-1:0]    lat_cnt;
  logic [INTERP_W-1:0] phase;
  logic [INTERP_W-1:0] last_ph;
  logic                run;

  assign last_ph  = INTERP_W'(fsg_pkg::last_phase(32'(interp)));
  assign lat_done = (lat_cnt == '0);
  assign run      = lat_done && !sleep;
  assign wrap_evt = run && (phase >= last_ph);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_cnt <= LAT_W'(RST_LAT);
    end else if (!lat_done) begin
      lat_cnt <= lat_cnt - LAT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sleep) begin
      phase <= '0;
    end else if (run) begin
      phase <= wrap_evt ? '0 : phase + INTERP_W'(1);
    end
  end
endmodule

// File: rtl/fsg_sync_out.sv
module fsg_sync_out (
  input  logic clk,
  input  logic rst_n,
  input  logic sleep,
  input  logic rise_evt,
  input  logic wrap_evt,
  output logic fsync
);
  logic pending;
  logic pend_any;

  assign pend_any = pending || wrap_evt;

  always_ff @(posedge clk) begin
    if (!rst_n || sleep) begin
      pending <= 1'b0;
      fsync   <= 1'b0;
    end else begin
      pending <= pend_any && !rise_evt;
      if (rise_evt) fsync <= pend_any;
    end
  end

  // R6
  sleep_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !fsync);

  // R4
  no_lost_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wrap_evt && pending && !rise_evt));
endmodule

// File: rtl/fsg_frame_sync.sv
module fsg_frame_sync #(
  parameter int INTERP_W = 16,
  parameter int RST_LAT  = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        sleep,
  input  logic [fsg_pkg::DIV_W-1:0]   sclk_div,
  input  logic [INTERP_W-1:0]         interp,
  output logic                        sclk_out,
  output logic                        sclk_en,
  output logic                        fsync
);
  logic rise_evt;
  logic half_done;
  logic lat_done;
  logic wrap_evt;

  fsg_sclk_div #(.DIV_W(fsg_pkg::DIV_W)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .div       (sclk_div),
    .sclk      (sclk_out),
    .rise_evt  (rise_evt),
    .half_done (half_done)
  );

  fsg_phase_acc #(.INTERP_W(INTERP_W), .RST_LAT(RST_LAT)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .interp   (interp),
    .lat_done (lat_done),
    .wrap_evt (wrap_evt)
  );

  fsg_sync_out u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .sleep    (sleep),
    .rise_evt (rise_evt),
    .wrap_evt (wrap_evt),
    .fsync    (fsync)
  );

  assign sclk_en = rise_evt;

  // R1
  sclk_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sclk_out) |-> $past(half_done));

  // R3
  fsync_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fsync) |-> $rose(sclk_out));

  // R2
  fsync_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fsync) |-> ($rose(sclk_out) || $past(sleep)));

  // R7
  fsync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fsync |-> lat_done);
endmodule

// File: tb/fsg_frame_sync_test.sv
`timescale 1ns/1ps
module fsg_frame_sync_test;
  localparam int LAT = 12;
  localparam int NV  = 6;
  // stimulus: divider, factor, frames; expected: short and long frame period
  localparam int VD [NV] = '{0, 1, 2, 4, 31, 3};
  localparam int VI [NV] = '{64, 100, 50, 333, 2000, 257};
  localparam int VN [NV] = '{12, 12, 12, 12, 8, 12};
  localparam int VLO[NV] = '{64, 100, 48, 330, 1984, 256};
  localparam int VHI[NV] = '{64, 100, 54, 340, 2048, 264};

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        sleep = 1'b0;
  logic [4:0]  div   = 5'd0;
  logic [15:0] interp = 16'd64;
  logic        sclk_out, sclk_en, fsync;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  fsg_frame_sync #(.INTERP_W(16), .RST_LAT(LAT)) uut (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .sclk_div(div),
    .interp(interp), .sclk_out(sclk_out), .sclk_en(sclk_en), .fsync(fsync)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input int d, input int i, input int nf,
                         input int lo, input int hi);
    int s = 2 * (d + 1);
    int t = 0, nr = 0, first = -1, last = -1, last_sr = -1;
    int hi_run = 0, f_run = 0;
    int bad_sp = 0, bad_hi = 0, bad_w = 0, bad_al = 0, bad_per = 0, bad_dr = 0;
    bit prev_s = 1'b0, prev_f = 1'b0;
    rst_n = 1'b0; sleep = 1'b0; div = 5'(d); interp = 16'(i);
    repeat (3) @(negedge clk);
    chk(fsync == 1'b0, "R8", "fsync in reset", int'(fsync), 0);
    chk(sclk_out == 1'b0, "R8", "sclk in reset", int'(sclk_out), 0);
    rst_n = 1'b1;
    while (nr < nf + 1 && t < i * (nf + 3) + 200) begin
      @(negedge clk);
      t++;
      if (sclk_out && !prev_s) begin
        if (last_sr >= 0 && t - last_sr != s) bad_sp++;
        last_sr = t;
      end
      if (!sclk_out && prev_s && hi_run != d + 1) bad_hi++;
      hi_run = sclk_out ? (prev_s ? hi_run + 1 : 1) : 0;
      if (fsync && !prev_f) begin
        if (!(sclk_out && !prev_s)) bad_al++;
        if (first < 0) first = t;
        else begin
          if (t - last != lo && t - last != hi) bad_per++;
          if ((t - first) - nr * i >= s || (t - first) - nr * i <= -s) bad_dr++;
        end
        last = t;
        nr++;
      end
      if (!fsync && prev_f && f_run != s) bad_w++;
      f_run = fsync ? (prev_f ? f_run + 1 : 1) : 0;
      prev_s = sclk_out;
      prev_f = fsync;
    end
    chk(bad_sp == 0, "R1", "sclk period errors", bad_sp, 0);
    chk(bad_hi == 0, "R1", "sclk high time errors", bad_hi, 0);
    chk(bad_w == 0, "R2", "fsync width errors", bad_w, 0);
    chk(bad_al == 0, "R3", "fsync not on sclk rise", bad_al, 0);
    chk(nr == nf + 1, "R4", "frames seen", nr, nf + 1);
    chk(bad_per == 0, "R4", "frame period errors", bad_per, 0);
    chk(bad_dr == 0, "R5", "drift beyond one sclk", bad_dr, 0);
    chk(first >= LAT + i && first <= LAT + i + s, "R7", "first fsync time",
        first, LAT + i);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < NV; v++) run_vec(VD[v], VI[v], VN[v], VLO[v], VHI[v]);

    // directed: sleep holds fsync low, then frames resume (R6)
    begin
      int highs = 0, wait_t = 0;
      rst_n = 1'b0; sleep = 1'b0; div = 5'd1; interp = 16'd100;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (400) @(negedge clk);
      sleep = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 400; k++) begin
        @(negedge clk);
        if (fsync) highs++;
      end
      chk(highs == 0, "R6", "fsync high samples in sleep", highs, 0);
      sleep = 1'b0;
      while (!fsync && wait_t < 1000) begin
        @(negedge clk);
        wait_t++;
      end
      chk(wait_t >= 99 && wait_t <= 100 + 4 + 1, "R6", "resume delay",
          wait_t, 100);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule